// File: doc/BRIEF.md
# Exception Pending/Enable Controller With Escalation

This block keeps one pending bit and one enable bit for each exception number of a small processor core. Exception numbers 0 to 15 are system exceptions; numbers from 16 upward belong to external interrupt lines, so that line n becomes exception 16+n. A single request output tells the core that at least one exception is both pending and enabled. Choosing which exception to take, vectoring and active-state tracking are left to the core.

Pending bits are fed from several places: level changes on the external interrupt lines, rising edges on system request lines and on fault-status lines, and one-cycle write strobes that set or clear enable and pending bits. When one of the three configurable faults (memory-management 4, bus 5, usage 6) is pending while it is disabled, the block moves that request to hard fault (3) and raises a sticky forced flag. The block also tracks a sleep flag for the core and pulses a wake output when an event arrives or, with send-event-on-pending selected, when an external interrupt becomes newly pending.

Top module: `exc_pend_ctrl`

## Requirements
- R1: After reset all pending bits, the request output, the wake pulse, the sleep flag, the fault status and the forced flag are 0; enables are 1 for exceptions 0, 2, 3, 11, 12, 14 and 15 and 0 for every other number.
- R2: A rising edge on external line n sets pending bit 16+n, visible on `pend_o` after the clock edge that samples it.
- R3: A falling edge on external line n clears pending bit 16+n after the clock edge that samples it.
- R4: A 1 in `en_set_i`/`pend_set_i` sets the matching bit and a 1 in `en_clr_i`/`pend_clr_i` clears it at the next clock; a 0 changes nothing; when set and clear hit the same bit in one cycle, clear wins.
- R5: When a pending write strobe and a line edge act on the same bit in the same cycle, the edge decides the result.
- R6: If exception 4, 5 or 6 is pending with its enable at 0, `pend_o` at once shows that bit as 0 and bit 3 as 1, the moved state is stored at the next clock, and `hf_forced_o` becomes 1 at that clock and stays 1 until reset.
- R7: `irq_o` is a register that, one clock later, equals the OR over all numbers of (`pend_o` AND `en_o`).
- R8: A rising edge on bit b of `fault_line_i` sets bit b of `fault_stat_o` (sticky until reset) and sets pending 4 for b in 7..0, pending 5 for b in 15..8, pending 6 for b in 31..16.
- R9: A rising edge on `sys_req_i[k]` sets pending k for k in {2, 3, 4, 5, 6, 11, 12, 14, 15}; edges on the other system lines are ignored.
- R10: While the core is sleeping and `sev_on_pend_i` is 1, an external pending bit going from 0 to 1 gives a one-cycle `wake_o` pulse and clears `sleeping_o`, both at the same clock as the new pending bit.
- R11: A rising edge on `event_i` while sleeping pulses `wake_o` and clears `sleeping_o`; in that update `irq_o` keeps its previous value.
- R12: `sleep_enter_i` sets `sleeping_o` at the next clock; a wake in the same cycle takes priority and leaves the flag clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_irq_i | input | NUM_EXT | External interrupt lines, level |
| sys_req_i | input | 16 | System exception request lines, rising edge |
| fault_line_i | input | 32 | Fault-status lines, rising edge |
| event_i | input | 1 | Wake event line, rising edge |
| sleep_enter_i | input | 1 | Core reports entering sleep |
| sev_on_pend_i | input | 1 | Send-event-on-pending setting |
| en_set_i | input | NUM_EXC | Enable set strobes |
| en_clr_i | input | NUM_EXC | Enable clear strobes |
| pend_set_i | input | NUM_EXC | Pending set strobes |
| pend_clr_i | input | NUM_EXC | Pending clear strobes |
| pend_o | output | NUM_EXC | Pending bits after escalation |
| en_o | output | NUM_EXC | Enable bits |
| irq_o | output | 1 | Interrupt request to the core |
| wake_o | output | 1 | One-cycle wake pulse |
| sleeping_o | output | 1 | Sleep flag |
| fault_stat_o | output | 32 | Sticky configurable fault status |
| hf_forced_o | output | 1 | Sticky flag: a fault was moved to hard fault |

## Verification
A corrupted pending or enable bit shows on `pend_o` or `en_o` after the very next clock edge and on `irq_o` one edge later, so the bench compares every output against its own model after each edge. A broken escalation path shows in the same cycle as the disabled fault bit appears, as bit 3 missing or bit 4..6 still set, and one cycle later as a missing forced flag. A wrong sleep flag surfaces only when the next wake source arrives, so the directed part puts the core to sleep before each wake source and the random part toggles sleep, events and the send-event setting often.

// File: rtl/epc_pkg.sv
package epc_pkg;
  localparam int SYS_COUNT  = 16;
  localparam int FAULT_BITS = 32;
  localparam int EXC_HARD   = 3;
  localparam int EXC_MEM    = 4;
  localparam int EXC_BUS    = 5;
  localparam int EXC_USAGE  = 6;

  // enables that come up set: 0,2,3,11,12,14,15
  localparam logic [SYS_COUNT-1:0] SYS_EN_AT_RESET = 16'hD80D;
  // system lines whose rising edge may set pending: 2..6,11,12,14,15
  localparam logic [SYS_COUNT-1:0] SYS_EDGE_MASK   = 16'hD87C;

  // moves disabled configurable faults onto hard fault
  function automatic logic [SYS_COUNT-1:0] escalate(input logic [SYS_COUNT-1:0] p,
                                                    input logic [SYS_COUNT-1:0] e);
    logic [SYS_COUNT-1:0] r;
    r = p;
    for (int k = EXC_MEM; k <= EXC_USAGE; k++) begin
      if (p[k] && !e[k]) begin
        r[k]        = 1'b0;
        r[EXC_HARD] = 1'b1;
      end
    end
    return r;
  endfunction

  function automatic logic escalating(input logic [SYS_COUNT-1:0] p,
                                      input logic [SYS_COUNT-1:0] e);
    return |(p[EXC_USAGE:EXC_MEM] & ~e[EXC_USAGE:EXC_MEM]);
  endfunction

  // fault-status rising edges to the fault they make pending
  function automatic logic [SYS_COUNT-1:0] fault_to_pend(input logic [FAULT_BITS-1:0] r);
    logic [SYS_COUNT-1:0] s;
    s            = '0;
    s[EXC_MEM]   = |r[7:0];
    s[EXC_BUS]   = |r[15:8];
    s[EXC_USAGE] = |r[31:16];
    return s;
  endfunction
endpackage

// File: rtl/epc_edge.sv
module epc_edge #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lines_i,
  output logic [W-1:0] chg_o
);
  logic [W-1:0] last_q;

  always_ff @(posedge clk) begin
    if (!rst_n) last_q <= '0;
    else        last_q <= lines_i;
  end

  assign chg_o = lines_i ^ last_q;
endmodule

// File: rtl/epc_pend_bank.sv
module epc_pend_bank #(
  parameter int N = 48
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] eff_i,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] hw_set_i,
  input  logic [N-1:0] hw_clr_i,
  output logic [N-1:0] pend_d_o,
  output logic [N-1:0] pend_q_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic nxt;
    logic q;
    always_comb begin
      if (hw_set_i[g])      nxt = 1'b1;
      else if (hw_clr_i[g]) nxt = 1'b0;
      else if (clr_i[g])    nxt = 1'b0;
      else if (set_i[g])    nxt = 1'b1;
      else                  nxt = eff_i[g];
    end
    always_ff @(posedge clk) begin
      if (!rst_n) q <= 1'b0;
      else        q <= nxt;
    end
    assign pend_d_o[g] = nxt;
    assign pend_q_o[g] = q;
  end
endmodule

// File: rtl/epc_en_bank.sv
module epc_en_bank #(
  parameter int N = 48,
  parameter logic [15:0] SYS_RST = 16'h0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] en_q_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    localparam logic RST_V = (g < 16) ? SYS_RST[g % 16] : 1'b0;
    logic q;
    always_ff @(posedge clk) begin
      if (!rst_n)        q <= RST_V;
      else if (clr_i[g]) q <= 1'b0;
      else if (set_i[g]) q <= 1'b1;
    end
    assign en_q_o[g] = q;
  end
endmodule

// File: rtl/epc_wake.sv
module epc_wake (
  input  logic clk,
  input  logic rst_n,
  input  logic sev_i,
  input  logic new_pend_i,
  input  logic evt_rise_i,
  input  logic sleep_enter_i,
  output logic sleeping_o,
  output logic wake_o
);
  logic sleep_q, wake_q, wake_now;

  assign wake_now = sleep_q & (evt_rise_i | (sev_i & new_pend_i));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sleep_q <= 1'b0;
      wake_q  <= 1'b0;
    end else begin
      wake_q <= wake_now;
      if (wake_now)           sleep_q <= 1'b0;
      else if (sleep_enter_i) sleep_q <= 1'b1;
    end
  end

  assign sleeping_o = sleep_q;
  assign wake_o     = wake_q;
endmodule

// File: rtl/exc_pend_ctrl.sv
module exc_pend_ctrl
  import epc_pkg::*;
#(
  parameter int NUM_EXT = 32,
  localparam int NUM_EXC = SYS_COUNT + NUM_EXT
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_EXT-1:0]    ext_irq_i,
  input  logic [SYS_COUNT-1:0]  sys_req_i,
  input  logic [FAULT_BITS-1:0] fault_line_i,
  input  logic                  event_i,
  input  logic                  sleep_enter_i,
  input  logic                  sev_on_pend_i,
  input  logic [NUM_EXC-1:0]    en_set_i,
  input  logic [NUM_EXC-1:0]    en_clr_i,
  input  logic [NUM_EXC-1:0]    pend_set_i,
  input  logic [NUM_EXC-1:0]    pend_clr_i,
  output logic [NUM_EXC-1:0]    pend_o,
  output logic [NUM_EXC-1:0]    en_o,
  output logic                  irq_o,
  output logic                  wake_o,
  output logic                  sleeping_o,
  output logic [FAULT_BITS-1:0] fault_stat_o,
  output logic                  hf_forced_o
);
  localparam int LINES = NUM_EXT + SYS_COUNT + FAULT_BITS + 1;
  localparam int SYS_LO = NUM_EXT;
  localparam int FLT_LO = NUM_EXT + SYS_COUNT;

  logic [LINES-1:0]      chg_w;
  logic [NUM_EXT-1:0]    ext_rise_w, ext_fall_w;
  logic [SYS_COUNT-1:0]  sys_rise_w;
  logic [FAULT_BITS-1:0] fault_rise_w;
  logic                  evt_rise_w;
  logic                  esc_w;
  logic                  new_ext_w;
  logic                  irq_req_w;
  logic [NUM_EXC-1:0]    pend_q_w, pend_d_w, pend_eff_w, en_q_w;
  logic [NUM_EXC-1:0]    hw_set_w, hw_clr_w;
  logic                  irq_q, forced_q;
  logic [FAULT_BITS-1:0] fstat_q;

  epc_edge #(.W(LINES)) u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .lines_i ({event_i, fault_line_i, sys_req_i, ext_irq_i}),
    .chg_o   (chg_w)
  );

  assign ext_rise_w   = chg_w[NUM_EXT-1:0] & ext_irq_i;
  assign ext_fall_w   = chg_w[NUM_EXT-1:0] & ~ext_irq_i;
  assign sys_rise_w   = chg_w[SYS_LO +: SYS_COUNT] & sys_req_i & SYS_EDGE_MASK;
  assign fault_rise_w = chg_w[FLT_LO +: FAULT_BITS] & fault_line_i;
  assign evt_rise_w   = chg_w[LINES-1] & event_i;

  // escalation works on the registered state, before this cycle's updates
  assign pend_eff_w = {pend_q_w[NUM_EXC-1:SYS_COUNT],
                       escalate(pend_q_w[SYS_COUNT-1:0], en_q_w[SYS_COUNT-1:0])};
  assign esc_w      = escalating(pend_q_w[SYS_COUNT-1:0], en_q_w[SYS_COUNT-1:0]);

  assign hw_set_w = {ext_rise_w, sys_rise_w | fault_to_pend(fault_rise_w)};
  assign hw_clr_w = {ext_fall_w, {SYS_COUNT{1'b0}}};

  epc_pend_bank #(.N(NUM_EXC)) u_pend (
    .clk      (clk),
    .rst_n    (rst_n),
    .eff_i    (pend_eff_w),
    .set_i    (pend_set_i),
    .clr_i    (pend_clr_i),
    .hw_set_i (hw_set_w),
    .hw_clr_i (hw_clr_w),
    .pend_d_o (pend_d_w),
    .pend_q_o (pend_q_w)
  );

  epc_en_bank #(.N(NUM_EXC), .SYS_RST(SYS_EN_AT_RESET)) u_en (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (en_set_i),
    .clr_i  (en_clr_i),
    .en_q_o (en_q_w)
  );

  assign new_ext_w = |(pend_d_w[NUM_EXC-1:SYS_COUNT] & ~pend_eff_w[NUM_EXC-1:SYS_COUNT]);

  epc_wake u_wake (
    .clk           (clk),
    .rst_n         (rst_n),
    .sev_i         (sev_on_pend_i),
    .new_pend_i    (new_ext_w),
    .evt_rise_i    (evt_rise_w),
    .sleep_enter_i (sleep_enter_i),
    .sleeping_o    (sleeping_o),
    .wake_o        (wake_o)
  );

  assign irq_req_w = |(pend_eff_w & en_q_w);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_q    <= 1'b0;
      forced_q <= 1'b0;
      fstat_q  <= '0;
    end else begin
      if (!evt_rise_w) irq_q <= irq_req_w;
      if (esc_w)       forced_q <= 1'b1;
      fstat_q <= fstat_q | fault_rise_w;
    end
  end

  assign pend_o       = pend_eff_w;
  assign en_o         = en_q_w;
  assign irq_o        = irq_q;
  assign hf_forced_o  = forced_q;
  assign fault_stat_o = fstat_q;
endmodule

// File: rtl/exc_pend_ctrl_chk.sv
module exc_pend_ctrl_chk #(
  parameter int NUM_EXT = 32,
  localparam int NUM_EXC = 16 + NUM_EXT
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_EXT-1:0] ext_irq_i,
  input logic [NUM_EXC-1:0] en_set_i,
  input logic [NUM_EXC-1:0] en_clr_i,
  input logic [NUM_EXC-1:0] pend_o,
  input logic [NUM_EXC-1:0] en_o,
  input logic               irq_o,
  input logic               wake_o,
  input logic               sleeping_o,
  input logic [31:0]        fault_stat_o,
  input logic               hf_forced_o,
  input logic               evt_rise_w,
  input logic               esc_w
);
  a_r2_ext_rise_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(ext_irq_i) & ~$past(ext_irq_i, 2) & ~pend_o[NUM_EXC-1:16]) == '0));

  a_r3_ext_fall_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ((~$past(ext_irq_i) & $past(ext_irq_i, 2) & pend_o[NUM_EXC-1:16]) == '0));

  a_r4_en_set: assert property (@(posedge clk) disable iff (!rst_n)
    ((en_set_i & ~en_clr_i) != '0) |=> (($past(en_set_i & ~en_clr_i) & ~en_o) == '0));

  a_r4_en_clr: assert property (@(posedge clk) disable iff (!rst_n)
    (en_clr_i != '0) |=> (($past(en_clr_i) & en_o) == '0));

  a_r6_no_disabled_fault: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_o[6:4] & ~en_o[6:4]) == 3'b000));

  a_r6_forced_after_esc: assert property (@(posedge clk) disable iff (!rst_n)
    esc_w |=> hf_forced_o);

  a_r6_forced_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    hf_forced_o |=> hf_forced_o);

  a_r7_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_rise_w |=> (irq_o == $past(|(pend_o & en_o))));

  a_r11_irq_holds: assert property (@(posedge clk) disable iff (!rst_n)
    evt_rise_w |=> $stable(irq_o));

  a_r8_status_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ((fault_stat_o & $past(fault_stat_o)) == $past(fault_stat_o)));

  a_r10_wake_clears_sleep: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |-> !sleeping_o);

  a_r12_wake_needs_sleep: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |-> $past(sleeping_o));
endmodule

bind exc_pend_ctrl exc_pend_ctrl_chk #(.NUM_EXT(NUM_EXT)) u_chk (.*);

// File: tb/exc_pend_ctrl_tb.sv
module exc_pend_ctrl_tb;
  localparam int NE = 32;
  localparam int N  = 16 + NE;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NE-1:0] ext_irq = '0;
  logic [15:0]   sys_req = '0;
  logic [31:0]   fault_line = '0;
  logic          event_in = 1'b0, sleep_enter = 1'b0, sev = 1'b0;
  logic [N-1:0]  en_set = '0, en_clr = '0, pend_set = '0, pend_clr = '0;
  logic [N-1:0]  pend_o, en_o;
  logic          irq_o, wake_o, sleeping_o, hf_forced_o;
  logic [31:0]   fault_stat_o;

  int vectors = 0;
  int fails = 0;
  bit done = 0;

  // bench model
  logic [N-1:0]  m_pend, m_en;
  logic          m_irq, m_wake, m_sleep, m_forced;
  logic [31:0]   m_fs;
  logic [NE-1:0] p_ext;
  logic [15:0]   p_sys;
  logic [31:0]   p_fault;
  logic          p_evt;

  always #5 clk = ~clk;

  exc_pend_ctrl #(.NUM_EXT(NE)) u_dut (
    .clk(clk), .rst_n(rst_n), .ext_irq_i(ext_irq), .sys_req_i(sys_req),
    .fault_line_i(fault_line), .event_i(event_in), .sleep_enter_i(sleep_enter),
    .sev_on_pend_i(sev), .en_set_i(en_set), .en_clr_i(en_clr),
    .pend_set_i(pend_set), .pend_clr_i(pend_clr), .pend_o(pend_o), .en_o(en_o),
    .irq_o(irq_o), .wake_o(wake_o), .sleeping_o(sleeping_o),
    .fault_stat_o(fault_stat_o), .hf_forced_o(hf_forced_o)
  );

  function automatic logic [N-1:0] b_esc(input logic [N-1:0] p, input logic [N-1:0] e);
    for (int k = 4; k <= 6; k++)
      if (p[k] && !e[k]) begin p[k] = 1'b0; p[3] = 1'b1; end
    return p;
  endfunction

  function automatic logic b_forced(input logic [N-1:0] p, input logic [N-1:0] e);
    logic f = 1'b0;
    for (int k = 4; k <= 6; k++) if (p[k] && !e[k]) f = 1'b1;
    return f;
  endfunction

  task automatic model_reset();
    m_pend = '0; m_en = '0;
    foreach (m_en[k]) if (k inside {0, 2, 3, 11, 12, 14, 15}) m_en[k] = 1'b1;
    m_irq = 0; m_wake = 0; m_sleep = 0; m_forced = 0; m_fs = '0;
    p_ext = '0; p_sys = '0; p_fault = '0; p_evt = 0;
  endtask

  task automatic model_step();
    logic [N-1:0] eff, nx;
    logic [NE-1:0] er, ef;
    logic [15:0] sr;
    logic [31:0] fr;
    logic evr, wk;
    eff = b_esc(m_pend, m_en);
    er = ext_irq & ~p_ext;  ef = ~ext_irq & p_ext;
    sr = sys_req & ~p_sys;  fr = fault_line & ~p_fault;
    evr = event_in & ~p_evt;
    nx = eff;
    for (int i = 0; i < N; i++) begin
      if (pend_clr[i]) nx[i] = 1'b0;
      else if (pend_set[i]) nx[i] = 1'b1;
    end
    for (int k = 0; k < 16; k++)
      if (sr[k] && (k inside {2, 3, 4, 5, 6, 11, 12, 14, 15})) nx[k] = 1'b1;
    if (|fr[7:0])   nx[4] = 1'b1;
    if (|fr[15:8])  nx[5] = 1'b1;
    if (|fr[31:16]) nx[6] = 1'b1;
    for (int i = 0; i < NE; i++) begin
      if (er[i]) nx[16+i] = 1'b1;
      if (ef[i]) nx[16+i] = 1'b0;
    end
    wk = m_sleep && (evr || (sev && (|(nx[N-1:16] & ~eff[N-1:16]))));
    if (b_forced(m_pend, m_en)) m_forced = 1'b1;
    m_fs = m_fs | fr;
    if (!evr) m_irq = |(eff & m_en);
    m_en = (m_en | en_set) & ~en_clr;
    if (wk) m_sleep = 1'b0; else if (sleep_enter) m_sleep = 1'b1;
    m_wake = wk;
    m_pend = nx;
    p_ext = ext_irq; p_sys = sys_req; p_fault = fault_line; p_evt = event_in;
  endtask

  task automatic cmp(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    cmp(tag, "pend_o", 64'(pend_o), 64'(b_esc(m_pend, m_en)));
    cmp(tag, "en_o", 64'(en_o), 64'(m_en));
    cmp(tag, "irq_o", 64'(irq_o), 64'(m_irq));
    cmp(tag, "wake_o", 64'(wake_o), 64'(m_wake));
    cmp(tag, "sleeping_o", 64'(sleeping_o), 64'(m_sleep));
    cmp(tag, "fault_stat_o", 64'(fault_stat_o), 64'(m_fs));
    cmp(tag, "hf_forced_o", 64'(hf_forced_o), 64'(m_forced));
  endtask

  // inputs are set at a falling edge before the call
  task automatic cyc(input string tag);
    @(posedge clk);
    model_step();
    @(negedge clk);
    check_all(tag);
  endtask

  task automatic quiet();
    en_set = '0; en_clr = '0; pend_set = '0; pend_clr = '0; sleep_enter = 0;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    void'($urandom(32'h5eed1234));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1");

    ext_irq[0] = 1'b1;                 cyc("R2");
    en_set[16] = 1'b1;                 cyc("R4"); quiet();
    cyc("R7");
    ext_irq[0] = 1'b0;                 cyc("R3");
    cyc("R7");
    ext_irq[1] = 1'b1; pend_clr[17] = 1'b1;
    pend_set[18] = 1'b1; pend_clr[18] = 1'b1; cyc("R5"); quiet();
    pend_set[20] = 1'b1;               cyc("R4"); quiet();
    pend_clr[20] = 1'b1; en_clr[0] = 1'b1; cyc("R4"); quiet();
    pend_set[4] = 1'b1;                cyc("R6"); quiet();
    cyc("R6");
    en_set[5] = 1'b1;                  cyc("R4"); quiet();
    fault_line[9] = 1'b1;              cyc("R8");
    fault_line[20] = 1'b1;             cyc("R8");
    cyc("R6");
    sys_req[1] = 1'b1; sys_req[13] = 1'b1; sys_req[14] = 1'b1; cyc("R9");
    sleep_enter = 1'b1;                cyc("R12"); quiet();
    sev = 1'b1; ext_irq[2] = 1'b1;     cyc("R10");
    cyc("R10");
    sleep_enter = 1'b1;                cyc("R12"); quiet();
    pend_set[19] = 1'b1; en_set[19] = 1'b1; cyc("R7"); quiet();
    event_in = 1'b1; pend_clr = '1;    cyc("R11"); quiet();
    cyc("R7");
    sleep_enter = 1'b1; event_in = 1'b0; cyc("R12"); quiet();
    event_in = 1'b1; sleep_enter = 1'b1; cyc("R12"); quiet();

    for (int t = 0; t < 4000; t++) begin
      ext_irq    = ext_irq ^ ($urandom & $urandom & $urandom);
      sys_req    = sys_req ^ 16'($urandom & $urandom);
      fault_line = fault_line ^ ($urandom & $urandom & $urandom & $urandom);
      event_in   = ($urandom % 4) == 0;
      sleep_enter = ($urandom % 6) == 0;
      sev        = $urandom % 2;
      en_set   = N'({$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom});
      en_clr   = N'({$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom});
      pend_set = N'({$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom});
      pend_clr = N'({$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom});
      cyc("random");
    end
    quiet();
    summary();
  end
endmodule